// File: doc/BRIEF.md
# Tiled Exception Mask Propagation Chain

The chain is four tiles in a line. Each tile collects exception flags for eight in-flight instruction blocks and passes what it knows one tile toward tile 0 on every clock. Tile 0's registered mask is the exception set that the rest of the machine sees. Any tile may raise an exception for one block per cycle. The tile gives it as a small code: a valid bit and a block index. Knowledge that starts in a far tile reaches the reporting end one hop per cycle.

A global flush mask applies to all tiles at once. It clears the selected blocks from every stored mask and from every mask that is still travelling between tiles, so a cancelled block never reappears later. A report for a block that is flushed in the same cycle is dropped. Each tile's next state is the union of its stored mask, the mask arriving from below and its own decoded report, with the flushed blocks removed. The farthest tile receives an all-zero incoming mask.

Top module: `exc_chain`

## Requirements
- R1: A synchronous active-high `rst` clears every tile, so `reported_mask` reads zero in the cycle after a reset edge.
- R2: Each tile's report is a 4-bit field of `tile_reports` at bits [4k+3:4k] for tile k. Bit 3 of the field is valid and bits 2:0 are the block index. A field whose valid bit is 0 has no effect on any mask.
- R3: An unflushed report presented at tile k before a clock edge sets its block bit in `reported_mask` after exactly k+1 clock edges, and not earlier.
- R4: Once a block bit is set in a tile, it stays set until a flush selects that block.
- R5: A flush bit clears that block in `reported_mask` after the edge that samples it. It also removes copies still in flight in lower tiles, so the block does not return without a new report.
- R6: A report whose block is selected by `flush_mask` in the same cycle is ignored. Reports from other tiles in that cycle for unflushed blocks are still accepted.
- R7: `reported_mask` is always a subset of a single-register reference. The reference ORs the decoded reports of all tiles, clears flushed blocks and accumulates the result each cycle.
- R8: Reports from several tiles in the same cycle, for different blocks, all reach `reported_mask` and are merged by OR.
- R9: Every report that is not flushed afterwards is visible in `reported_mask` within four clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_mask | input | 8 | Global flush, one bit per block |
| tile_reports | input | 16 | Per-tile report codes, tile k in bits [4k+3:4k] |
| reported_mask | output | 8 | Tile 0 stored exception mask |

## Verification
The bench builds the chain with its default size: four tiles and eight blocks. With this size the 3-bit index reaches every block, and the longest path, from tile 3, is four hops, which sets the liveness window. Directed tasks present a report at each tile distance, flush blocks while they are in flight, and collide a report with a flush in the same cycle. A long pseudo-random run compares the reporting tile against a single-register reference every cycle, and tracks a deadline for each block to check liveness.

// File: rtl/exc_chain_pkg.sv
package exc_chain_pkg;

  localparam int DEF_TILES  = 4;
  localparam int DEF_BLOCKS = 8;

  // width of one tile's report field: index plus the valid bit on top
  function automatic int report_width(input int blocks);
    return $clog2(blocks) + 1;
  endfunction

endpackage

// File: rtl/exc_local_decoder.sv
module exc_local_decoder #(
  parameter int BLOCKS = exc_chain_pkg::DEF_BLOCKS,
  localparam int IDX_W  = $clog2(BLOCKS),
  localparam int CODE_W = IDX_W + 1
) (
  input  logic [CODE_W-1:0] report_code,
  input  logic [BLOCKS-1:0] flush_mask,
  output logic [BLOCKS-1:0] hit_mask,
  output logic              dropped
);

  // one-hot expansion of a block index, all zero when not valid
  function automatic logic [BLOCKS-1:0] expand(input logic valid,
                                               input logic [IDX_W-1:0] idx);
    logic [BLOCKS-1:0] m;
    for (int b = 0; b < BLOCKS; b++) begin
      m[b] = valid && (idx == IDX_W'(b));
    end
    return m;
  endfunction

  logic              code_valid;
  logic [IDX_W-1:0]  code_idx;
  logic [BLOCKS-1:0] raw_mask;

  assign code_valid = report_code[CODE_W-1];
  assign code_idx   = report_code[IDX_W-1:0];
  assign raw_mask   = expand(code_valid, code_idx);

  // a report for a block being flushed this cycle is discarded
  assign hit_mask   = raw_mask & ~flush_mask;
  assign dropped    = |(raw_mask & flush_mask);

endmodule

// File: rtl/exc_tile.sv
module exc_tile #(
  parameter int BLOCKS = exc_chain_pkg::DEF_BLOCKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLOCKS-1:0] from_below,
  input  logic [BLOCKS-1:0] local_hit,
  input  logic [BLOCKS-1:0] flush_mask,
  output logic [BLOCKS-1:0] held
);

  function automatic logic [BLOCKS-1:0] merge_next(
      input logic [BLOCKS-1:0] stored,
      input logic [BLOCKS-1:0] incoming,
      input logic [BLOCKS-1:0] fresh,
      input logic [BLOCKS-1:0] flush);
    return (stored | incoming | fresh) & ~flush;
  endfunction

  logic [BLOCKS-1:0] held_next;

  assign held_next = merge_next(held, from_below, local_hit, flush_mask);

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= held_next;
  end

endmodule

// File: rtl/exc_chain.sv
module exc_chain #(
  parameter int TILES  = exc_chain_pkg::DEF_TILES,
  parameter int BLOCKS = exc_chain_pkg::DEF_BLOCKS,
  localparam int CODE_W = exc_chain_pkg::report_width(BLOCKS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BLOCKS-1:0]       flush_mask,
  input  logic [TILES*CODE_W-1:0] tile_reports,
  output logic [BLOCKS-1:0]       reported_mask
);

  // named internal events for the checker
  logic [BLOCKS-1:0]       tile_held  [TILES];
  logic [BLOCKS-1:0]       tile_hit   [TILES];
  logic [BLOCKS-1:0]       tile_in    [TILES];
  logic [TILES-1:0]        local_dropped;
  logic [TILES*BLOCKS-1:0] held_flat;

  for (genvar k = 0; k < TILES; k++) begin : g_tile
    exc_local_decoder #(.BLOCKS(BLOCKS)) u_dec (
      .report_code (tile_reports[k*CODE_W +: CODE_W]),
      .flush_mask  (flush_mask),
      .hit_mask    (tile_hit[k]),
      .dropped     (local_dropped[k])
    );

    if (k == TILES - 1) begin : g_end
      assign tile_in[k] = '0;
    end else begin : g_link
      assign tile_in[k] = tile_held[k+1];
    end

    exc_tile #(.BLOCKS(BLOCKS)) u_tile (
      .clk        (clk),
      .rst        (rst),
      .from_below (tile_in[k]),
      .local_hit  (tile_hit[k]),
      .flush_mask (flush_mask),
      .held       (tile_held[k])
    );

    assign held_flat[k*BLOCKS +: BLOCKS] = tile_held[k];
  end

  assign reported_mask = tile_held[0];

endmodule

// File: rtl/exc_chain_checker.sv
module exc_chain_checker #(
  parameter int TILES  = 4,
  parameter int BLOCKS = 8,
  localparam int IDX_W  = $clog2(BLOCKS),
  localparam int CODE_W = IDX_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [BLOCKS-1:0]       flush_mask,
  input logic [TILES*CODE_W-1:0] tile_reports,
  input logic [BLOCKS-1:0]       reported_mask,
  input logic [TILES*BLOCKS-1:0] held_flat,
  input logic [TILES-1:0]        dropped
);

  // single-register reference accumulated from the raw reports
  logic [BLOCKS-1:0] ref_mask;
  logic [BLOCKS-1:0] ref_new;

  always_comb begin
    ref_new = '0;
    for (int k = 0; k < TILES; k++) begin
      if (tile_reports[k*CODE_W + IDX_W]) begin
        ref_new[tile_reports[k*CODE_W +: IDX_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_mask <= '0;
    else     ref_mask <= (ref_mask | ref_new) & ~flush_mask;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (reported_mask == '0));

  assert_subset_R7: assert property (@(posedge clk) disable iff (rst)
    ((reported_mask & ~ref_mask) == '0));

  assert_flush_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ((reported_mask & $past(flush_mask)) == '0));

  assert_dropped_seen_R6: assert property (@(posedge clk) disable iff (rst)
    (dropped != '0) |-> (flush_mask != '0));

  for (genvar k = 0; k < TILES; k++) begin : g_chk
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (($past(held_flat[k*BLOCKS +: BLOCKS]) & ~$past(flush_mask)
        & ~held_flat[k*BLOCKS +: BLOCKS]) == '0));

    assert_local_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (tile_reports[k*CODE_W + IDX_W] &&
       !flush_mask[tile_reports[k*CODE_W +: IDX_W]])
      |=> held_flat[k*BLOCKS + int'($past(tile_reports[k*CODE_W +: IDX_W]))]);

    if (k > 0) begin : g_hop
      assert_hop_R3: assert property (@(posedge clk) disable iff (rst)
        (($past(held_flat[k*BLOCKS +: BLOCKS]) & ~$past(flush_mask)
          & ~held_flat[(k-1)*BLOCKS +: BLOCKS]) == '0));
    end
  end

endmodule

bind exc_chain exc_chain_checker #(.TILES(TILES), .BLOCKS(BLOCKS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush_mask    (flush_mask),
  .tile_reports  (tile_reports),
  .reported_mask (reported_mask),
  .held_flat     (held_flat),
  .dropped       (local_dropped)
);

// File: tb/test_exc_chain.sv
module test_exc_chain;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  flush_mask = '0;
  logic [15:0] tile_reports = '0;
  logic [7:0]  reported_mask;

  int total = 0;
  int bad = 0;
  logic [7:0] bench_ref = '0;
  int due [8];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  exc_chain i_exc_chain (
    .clk           (clk),
    .rst           (rst),
    .flush_mask    (flush_mask),
    .tile_reports  (tile_reports),
    .reported_mask (reported_mask)
  );

  function automatic logic [15:0] rpt(input int tile, input int blk);
    logic [15:0] v;
    v = {12'd0, 1'b1, 3'(blk)};
    return v << (tile * 4);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at the following negedge
  task automatic step(input logic [7:0] fl, input logic [15:0] rep);
    logic [7:0] dec;
    dec = '0;
    flush_mask   = fl;
    tile_reports = rep;
    for (int b = 0; b < 8; b++) if (fl[b]) due[b] = 0;
    for (int k = 0; k < 4; k++) begin
      if (rep[k*4+3] && !fl[rep[k*4 +: 3]]) begin
        dec[rep[k*4 +: 3]] = 1'b1;
        if (due[rep[k*4 +: 3]] == 0 || k + 1 < due[rep[k*4 +: 3]])
          due[rep[k*4 +: 3]] = k + 1;
      end
    end
    @(posedge clk);
    bench_ref = (bench_ref | dec) & ~fl;
    @(negedge clk);
    flush_mask   = '0;
    tile_reports = '0;
    check("R7 subset", reported_mask & ~bench_ref, 8'h00);
    for (int b = 0; b < 8; b++) begin
      if (due[b] > 0) begin
        due[b]--;
        if (due[b] == 0) check("R9 liveness", {7'd0, reported_mask[b]}, 8'h01);
      end
    end
  endtask

  task automatic clear_all();
    step(8'hFF, '0);
  endtask

  task automatic t_reset();
    check("R1 reset", reported_mask, 8'h00);
  endtask

  task automatic t_latency();
    for (int k = 0; k < 4; k++) begin
      clear_all();
      step(8'h00, rpt(k, k + 2));
      check("R3 latency", reported_mask, (k == 0) ? 8'(1 << (k + 2)) : 8'h00);
      for (int c = 2; c <= 4; c++) begin
        step(8'h00, '0);
        check("R3 latency", reported_mask, (c >= k + 1) ? 8'(1 << (k + 2)) : 8'h00);
      end
    end
  endtask

  task automatic t_invalid();
    clear_all();
    step(8'h00, 16'h0005 | 16'h0070);
    for (int c = 0; c < 4; c++) step(8'h00, '0);
    check("R2 invalid ignored", reported_mask, 8'h00);
    step(8'h00, 16'h000D);
    check("R2 valid block5", reported_mask, 8'h20);
  endtask

  task automatic t_sticky();
    clear_all();
    step(8'h00, rpt(2, 1));
    for (int c = 0; c < 8; c++) step(8'h00, '0);
    check("R4 sticky", reported_mask, 8'h02);
    step(8'hFD, '0);
    check("R4 other flush keeps", reported_mask, 8'h02);
  endtask

  task automatic t_flush();
    clear_all();
    step(8'h00, rpt(0, 0));
    check("R5 stored set", reported_mask, 8'h01);
    step(8'h01, '0);
    check("R5 stored cleared", reported_mask, 8'h00);
    step(8'h00, rpt(3, 6));
    step(8'h40, '0);
    for (int c = 0; c < 4; c++) begin
      step(8'h00, '0);
      check("R5 in-flight cleared", reported_mask, 8'h00);
    end
  endtask

  task automatic t_same_cycle();
    clear_all();
    step(8'h10, rpt(1, 4) | rpt(2, 3));
    step(8'h00, '0);
    step(8'h00, '0);
    check("R6 flushed report ignored", reported_mask, 8'h08);
    step(8'h00, '0);
    step(8'h00, '0);
    check("R6 still ignored", reported_mask, 8'h08);
  endtask

  task automatic t_merge();
    clear_all();
    step(8'h00, rpt(0, 0) | rpt(1, 3) | rpt(2, 5) | rpt(3, 7));
    for (int c = 0; c < 3; c++) step(8'h00, '0);
    check("R8 merge", reported_mask, 8'hA9);
  endtask

  task automatic t_random();
    logic [15:0] rep;
    logic [7:0]  fl;
    clear_all();
    for (int n = 0; n < 400; n++) begin
      rep = '0;
      for (int k = 0; k < 4; k++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        if (seed[1:0] == 2'b00) rep[k*4 +: 4] = {1'b1, seed[6:4]};
        else if (seed[1:0] == 2'b01) rep[k*4 +: 4] = {1'b0, seed[6:4]};
      end
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      fl = (seed[2:0] == 3'd0) ? seed[15:8] : 8'h00;
      step(fl, rep);
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) due[b] = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_invalid();
    t_sticky();
    t_flush();
    t_same_cycle();
    t_merge();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule